// File: doc/BRIEF.md
# Fully Associative Byte Cache with First-In-First-Out Replacement

This block sits between a processor and a slow byte-wide memory. It keeps a small number of address/byte pairs in a content-addressable store. Every stored word carries the address in its upper bits and the byte in its lower bits. A lookup compares the request address against every valid word at once, through a fixed mask that covers the address field only. A read that hits returns the cached byte in the same cycle. A read that misses goes to the memory port, passes the returned byte to the processor in the cycle the memory acknowledges, and stores the pair in the cache.

Writes always go through to memory. A write that hits also refreshes the cached byte. A write that misses allocates nothing. Free locations are filled starting at location 0 and moving upward. Once every location holds data, a single pointer register picks the victim, so words are overwritten in the order they were loaded. Two counters record completed hits and misses, which gives the hit ratio.

Top module: `fa_fifo_cache`

## Requirements
- R1: After reset every location is invalid, both counters read 0, and the first read of any address is a miss.
- R2: A read miss drives mem_req=1, mem_we=0 and mem_addr=cpu_addr, and holds cpu_done=0 until mem_ack. In the cycle where mem_ack=1, cpu_done=1 and cpu_rdata equals mem_rdata.
- R3: A read hit completes in the cycle of the request, with cpu_done=1 and mem_req=0, and returns the byte last stored for that address.
- R4: A read miss stores the address/byte pair in the lowest-numbered invalid location while one exists.
- R5: When no location is free, a read miss overwrites the location loaded earliest, so the loaded addresses leave the cache in loading order. After the last location, replacement wraps back to location 0.
- R6: Hits do not change the replacement order.
- R7: Every write drives mem_req=1, mem_we=1, mem_addr=cpu_addr and mem_wdata=cpu_wdata, and completes with cpu_done=1 in the cycle where mem_ack=1.
- R8: A write hit replaces the cached byte, so a later read of that address hits and returns the new byte.
- R9: A write miss allocates no location, so a later read of that address misses.
- R10: Each completed access adds exactly 1 to hit_count if its address was cached when it completed, and to miss_count otherwise. Cycles without completion leave both counters unchanged.
- R11: A hit requires all 16 address bits to match. An address that differs from a cached one in any single bit misses.
- R12: cpu_done is never 1 while cpu_req is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Access address |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid with cpu_done on reads |
| cpu_done | output | 1 | Access completes this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid with mem_ack |
| mem_ack | input | 1 | Memory completes the request this cycle |
| hit_count | output | 16 | Completed hits |
| miss_count | output | 16 | Completed misses |

## Verification
The bench builds the block with its default values: 16-bit addresses, 8-bit data, 8 locations and the first-free fill variant. With only 8 locations, eviction and pointer wrap occur many times within a few hundred accesses. The bench flips every single address bit of a cached address, and it runs a long sweep that cycles through 12 addresses against 8 locations, with writes mixed in and memory latencies from 0 to 3 cycles. A replacement model in the bench predicts every hit, miss, returned byte and counter value.

// File: rtl/fac_pkg.sv
package fac_pkg;
   // fill variant selectors
   localparam int FILL_POINTER_ONLY = 0;
   localparam int FILL_FIRST_FREE   = 1;

   // mask that keeps the address field of a stored word and drops the data field
   function automatic logic [63:0] addr_field_mask(input int aw, input int dw);
      logic [63:0] m;
      m = '0;
      for (int i = 0; i < aw; i++) m[dw + i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/fac_match.sv
module fac_match
   import fac_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   localparam int WORD_W = ADDR_W + DATA_W
) (
   input  logic [ENTRIES-1:0][WORD_W-1:0] words,
   input  logic [ENTRIES-1:0]             valid,
   input  logic [WORD_W-1:0]              key,
   output logic [ENTRIES-1:0]             match,
   output logic                           any_hit,
   output logic [WORD_W-1:0]              hit_word
);
   localparam logic [63:0] MASK_WIDE = addr_field_mask(ADDR_W, DATA_W);
   localparam logic [WORD_W-1:0] MASK = MASK_WIDE[WORD_W-1:0];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
      assign match[g] = valid[g] & (((words[g] ^ key) & MASK) == '0);
   end

   assign any_hit = |match;

   always_comb begin
      hit_word = '0;
      for (int i = 0; i < ENTRIES; i++)
         if (match[i]) hit_word = hit_word | words[i];
   end
endmodule

// File: rtl/fac_victim.sv
module fac_victim
   import fac_pkg::*;
#(
   parameter int ENTRIES   = 8,
   parameter int FILL_MODE = FILL_FIRST_FREE,
   localparam int IDX_W    = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] valid,
   input  logic               fill_en,
   output logic [IDX_W-1:0]   victim
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   logic [IDX_W-1:0] ptr_q;

   if (FILL_MODE == FILL_FIRST_FREE) begin : g_first_free
      logic [IDX_W-1:0] first_free;
      logic             any_free;
      always_comb begin
         first_free = '0;
         any_free   = 1'b0;
         for (int i = ENTRIES - 1; i >= 0; i--)
            if (!valid[i]) begin
               first_free = IDX_W'(i);
               any_free   = 1'b1;
            end
      end
      assign victim = any_free ? first_free : ptr_q;
   end else begin : g_ptr_only
      logic unused_valid;
      assign unused_valid = ^valid;
      assign victim = ptr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr_q <= '0;
      else if (fill_en) ptr_q <= (victim == LAST) ? '0 : victim + IDX_W'(1);
   end
endmodule

// File: rtl/fac_counters.sv
module fac_counters #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done,
   input  logic             was_hit,
   output logic [CNT_W-1:0] hits,
   output logic [CNT_W-1:0] misses
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hits   <= '0;
         misses <= '0;
      end else if (done) begin
         if (was_hit) hits   <= hits + CNT_W'(1);
         else         misses <= misses + CNT_W'(1);
      end
   end
endmodule

// File: rtl/fa_fifo_cache.sv
module fa_fifo_cache
   import fac_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int ENTRIES   = 8,
   parameter int CNT_W     = 16,
   parameter int FILL_MODE = FILL_FIRST_FREE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack,
   output logic [CNT_W-1:0]  hit_count,
   output logic [CNT_W-1:0]  miss_count
);
   localparam int WORD_W = ADDR_W + DATA_W;
   localparam int IDX_W  = $clog2(ENTRIES);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("ENTRIES must be at least 2");
   end
   if (WORD_W > 64) begin : g_bad_width
      $error("ADDR_W + DATA_W must not exceed 64");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end
   if (FILL_MODE != FILL_FIRST_FREE && FILL_MODE != FILL_POINTER_ONLY) begin : g_bad_mode
      $error("unknown FILL_MODE");
   end

   logic [ENTRIES-1:0][WORD_W-1:0] words_q;
   logic [ENTRIES-1:0]             valid_q;
   logic [ENTRIES-1:0]             match;
   logic                           is_hit;
   logic [WORD_W-1:0]              hit_word;
   logic [IDX_W-1:0]               victim;
   logic                           fill_en;
   logic                           wr_update;

   fac_match #(
      .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_match (
      .words   (words_q),
      .valid   (valid_q),
      .key     ({cpu_addr, {DATA_W{1'b0}}}),
      .match   (match),
      .any_hit (is_hit),
      .hit_word(hit_word)
   );

   fac_victim #(
      .ENTRIES(ENTRIES), .FILL_MODE(FILL_MODE)
   ) u_victim (
      .clk    (clk),
      .rst_n  (rst_n),
      .valid  (valid_q),
      .fill_en(fill_en),
      .victim (victim)
   );

   // memory side: writes always go out, reads only on a miss
   assign mem_req   = cpu_req & (cpu_we | ~is_hit);
   assign mem_we    = cpu_req & cpu_we;
   assign mem_addr  = cpu_addr;
   assign mem_wdata = cpu_wdata;

   assign cpu_done  = cpu_req & (mem_req ? mem_ack : 1'b1);
   assign cpu_rdata = is_hit ? hit_word[DATA_W-1:0] : mem_rdata;

   assign fill_en   = cpu_req & ~cpu_we & ~is_hit & mem_ack;
   assign wr_update = cpu_req &  cpu_we &  is_hit & mem_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         words_q <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (fill_en && victim == IDX_W'(i)) begin
               words_q[i] <= {cpu_addr, mem_rdata};
               valid_q[i] <= 1'b1;
            end else if (wr_update && match[i]) begin
               words_q[i][DATA_W-1:0] <= cpu_wdata;
            end
         end
      end
   end

   fac_counters #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .done   (cpu_done),
      .was_hit(is_hit),
      .hits   (hit_count),
      .misses (miss_count)
   );
endmodule

// File: rtl/fa_fifo_cache_chk.sv
module fa_fifo_cache_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [DATA_W-1:0] cpu_wdata,
   input logic [DATA_W-1:0] cpu_rdata,
   input logic              cpu_done,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [DATA_W-1:0] mem_rdata,
   input logic              mem_ack,
   input logic [CNT_W-1:0]  hit_count,
   input logic [CNT_W-1:0]  miss_count
);
   logic [CNT_W-1:0] total;
   assign total = hit_count + miss_count;

   // R12
   done_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> cpu_req);

   // R2
   read_miss_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_we && mem_req) |->
         (!mem_we && mem_addr == cpu_addr && cpu_done == mem_ack
          && (!mem_ack || cpu_rdata == mem_rdata)));

   // R3
   read_hit_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_we && !mem_req) |-> cpu_done);

   // R7
   write_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_we) |->
         (mem_req && mem_we && mem_addr == cpu_addr && mem_wdata == cpu_wdata
          && cpu_done == mem_ack));

   // R10
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> total == $past(total) + CNT_W'(1));

   // R10
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_done |=> $stable(total));
endmodule

bind fa_fifo_cache fa_fifo_cache_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
   .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
   .cpu_done(cpu_done), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
   .mem_ack(mem_ack), .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/fa_fifo_cache_tb.sv
module fa_fifo_cache_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 8;
   localparam int N  = 8;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic [DW-1:0] cpu_rdata;
   logic          cpu_done;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          mem_ack = 1'b0;
   logic [CW-1:0] hit_count, miss_count;

   always #(CLK_PERIOD / 2) clk = ~clk;

   fa_fifo_cache u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_done(cpu_done), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ack(mem_ack), .hit_count(hit_count), .miss_count(miss_count)
   );

   int checks = 0;
   int fails  = 0;

   // replacement model: fills in loading order, pointer wraps
   logic [AW-1:0] m_tag [N];
   logic [DW-1:0] m_dat [N];
   bit            m_v   [N];
   int            m_ptr;
   int            exp_hits, exp_miss;
   logic [DW-1:0] wr_map [logic [AW-1:0]];

   task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] memval(logic [AW-1:0] a);
      if (wr_map.exists(a)) return wr_map[a];
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
   endfunction

   function automatic int m_find(logic [AW-1:0] a);
      for (int i = 0; i < N; i++)
         if (m_v[i] && m_tag[i] == a) return i;
      return -1;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cpu_req = 1'b0; mem_ack = 1'b0;
      for (int i = 0; i < N; i++) m_v[i] = 1'b0;
      m_ptr = 0; exp_hits = 0; exp_miss = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check_eq("R1", "hit_count after reset", 32'(hit_count), 0);
      check_eq("R1", "miss_count after reset", 32'(miss_count), 0);
      check_eq("R12", "cpu_done idle", 32'(cpu_done), 0);
      check_eq("R1", "mem_req idle", 32'(mem_req), 0);
   endtask

   task automatic access(bit we, logic [AW-1:0] addr, logic [DW-1:0] wd, int lat, string req);
      int idx;
      bit hit;
      logic [DW-1:0] rv;
      idx = m_find(addr);
      hit = (idx >= 0);
      rv  = memval(addr);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd; mem_ack = 1'b0;
      #1;
      if (!we && hit) begin
         check_eq(req, "read hit mem_req", 32'(mem_req), 0);
         check_eq(req, "read hit done", 32'(cpu_done), 1);
         check_eq(req, "read hit data", 32'(cpu_rdata), 32'(m_dat[idx]));
      end else begin
         check_eq(req, "mem_req", 32'(mem_req), 1);
         check_eq(we ? "R7" : "R2", "mem_we", 32'(mem_we), 32'(we));
         check_eq(we ? "R7" : "R2", "mem_addr", 32'(mem_addr), 32'(addr));
         if (we) check_eq("R7", "mem_wdata", 32'(mem_wdata), 32'(wd));
         check_eq("R2", "done before ack", 32'(cpu_done), 0);
         for (int c = 0; c < lat; c++) begin
            @(negedge clk);
            #1;
            check_eq("R2", "waiting done", 32'(cpu_done), 0);
         end
         mem_ack = 1'b1;
         mem_rdata = we ? 8'h00 : rv;
         #1;
         check_eq(we ? "R7" : "R2", "done on ack", 32'(cpu_done), 1);
         if (!we) check_eq("R2", "miss data", 32'(cpu_rdata), 32'(rv));
      end
      @(posedge clk);
      @(negedge clk);
      cpu_req = 1'b0; mem_ack = 1'b0;
      if (we) begin
         if (hit) m_dat[idx] = wd;
         wr_map[addr] = wd;
      end else if (!hit) begin
         m_tag[m_ptr] = addr; m_dat[m_ptr] = rv; m_v[m_ptr] = 1'b1;
         m_ptr = (m_ptr + 1) % N;
      end
      if (hit) exp_hits++; else exp_miss++;
      #1;
      check_eq("R10", "hit_count", 32'(hit_count), 32'(exp_hits));
      check_eq("R10", "miss_count", 32'(miss_count), 32'(exp_miss));
      check_eq("R12", "done after release", 32'(cpu_done), 0);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      do_reset();
      // R1, R2: cold miss, then R3 hit
      access(1'b0, 16'h1234, 8'h00, 3, "R1");
      access(1'b0, 16'h1234, 8'h00, 0, "R3");
      // R11: every single-bit neighbour misses
      for (int b = 0; b < AW; b++)
         access(1'b0, 16'h1234 ^ (16'h1 << b), 8'h00, b % 3, "R11");

      // R1: reset empties the cache
      do_reset();
      access(1'b0, 16'h1234, 8'h00, 1, "R1");
      do_reset();

      // R4: fill all locations, R6: hits leave the order untouched
      for (int i = 0; i < N; i++) access(1'b0, 16'h4000 + 16'(i) * 16'h0101, 8'h00, i % 2, "R4");
      for (int i = N - 1; i >= 0; i--) access(1'b0, 16'h4000 + 16'(i) * 16'h0101, 8'h00, 0, "R6");
      // R5: next miss evicts the first loaded, wraps to location 0
      access(1'b0, 16'h4808, 8'h00, 2, "R5");
      for (int i = 1; i < N; i++) access(1'b0, 16'h4000 + 16'(i) * 16'h0101, 8'h00, 0, "R5");
      access(1'b0, 16'h4000, 8'h00, 1, "R5");
      access(1'b0, 16'h4101, 8'h00, 1, "R5");

      // R7, R8: write hit refreshes the cached byte
      access(1'b1, 16'h4808, 8'h3C, 2, "R8");
      access(1'b0, 16'h4808, 8'h00, 0, "R8");
      // R7, R9: write miss does not allocate
      access(1'b1, 16'hBEEF, 8'h77, 0, "R9");
      access(1'b0, 16'hBEEF, 8'h00, 1, "R9");
      access(1'b0, 16'hBEEF, 8'h00, 0, "R3");

      // R5/R6 sweep: 12 addresses over 8 locations with writes mixed in
      for (int i = 0; i < 240; i++) begin
         logic [AW-1:0] a;
         a = 16'h8000 + 16'((i * 7) % 12) * 16'h0111;
         if (i % 5 == 0) access(1'b1, a, 8'(i), i % 4, "R8");
         else            access(1'b0, a, 8'h00, i % 4, "R5");
      end
      finish_run();
   end
endmodule